// File: doc/BRIEF.md
# Memory Card Block Write Receiver

This block is the card-side receiver for host-to-card block writes over a one-bit data line. The command layer reaches it as single-cycle strobes: start a write (single or multi-block, with the block length, the starting offset inside a block and a write-protect hit flag), stop, select and deselect. Each data block arrives as a start bit, the data bits, a 16-bit CRC and an end bit. The receiver checks the CRC and returns a five-bit status token. When the block is good, it starts a programming delay of fixed length. While that delay runs, it pulls the line low for as long as the card is selected.

Errors abort the transfer in three ways. A bad CRC discards the block and makes the receiver deaf to the rest of the transfer. A block that would cross a block boundary, when misaligned writes are disabled, is refused before it starts, and the receiver then waits for stop. A write into a protected area is refused at the start. A status-read strobe returns a ready flag and three sticky error flags, and the error flags clear when they are read.

The state machine has seven states. In `S_IDLE` the receiver waits for a write start. `S_WAIT_START` waits for a start bit. `S_SHIFT` shifts in the data and CRC bits. `S_END` takes the end bit and gives the verdict. `S_GAP` is a single silent cycle. `S_TOK` drives the token. `S_WAIT_STOP` ignores all data until stop.

The transitions are these:
- Start from idle goes to `S_WAIT_START`. It stays in idle when the area is protected, and goes to `S_WAIT_STOP` when the first block is misaligned.
- A start bit seen while not programming moves from `S_WAIT_START` to `S_SHIFT`.
- The last CRC bit moves from `S_SHIFT` to `S_END`.
- `S_END` always moves to `S_GAP`, and `S_GAP` always moves to `S_TOK`.
- After the last token bit, the next state depends on the transfer. A single-block write, or a failed single block, returns to `S_IDLE`. A good multi-block write with an aligned next block returns to `S_WAIT_START`. A failed multi-block write, or a misaligned next block, goes to `S_WAIT_STOP`.
- Stop or deselect returns to `S_IDLE` from any state.

Top module: `card_wr_rx`

## Requirements
- R1: After reset, `dat_oe` is 0, `stat_q` is 0 and the card is deselected. The first status read returns 4'b1000.
- R2: A block is a 0 start bit, then `len` data bits MSB first, then 16 CRC bits MSB first, then an end bit. The CRC is x^16+x^12+x^5+1 with initial value 0, computed over the data bits.
- R3: The token's first bit is driven two cycles after the end bit, and the token lasts five cycles. Its bits are 0, then a three-bit code sent MSB first, then 1. The code is 010 for an accepted block and 101 for a CRC error. The card does not drive the line in the cycle between the end bit and the token.
- R4: On a CRC error the block is not programmed, so ready stays 1 and no busy is driven, and status bit 0 is set. In a multi-block write, every later block gets no token until stop.
- R5: An accepted block starts programming, which lasts PROG_CYC cycles counted from the end-bit cycle. While programming, the ready flag is 0. The card drives the line low whenever it is selected and not shifting or sending a token, so busy is seen for PROG_CYC-6 cycles after the token.
- R6: The misalignment check runs at write start and before each further block of a multi-block write. It applies only when `cfg_misalign_ok` is 0. A block is misaligned when the current offset plus `len` exceeds BLK_BITS. A misaligned block sets status bit 2, gets no token, and the receiver waits for stop. The offset advances by `len` modulo BLK_BITS after each accepted block.
- R7: A write start with `cmd_wp` set sets status bit 1. No block of that transfer is received.
- R8: Deselect releases the line on the next cycle and abandons any transfer. Programming continues, and its total length is unchanged.
- R9: Reselect during programming restores the low busy level on the next cycle.
- R10: A status read updates `stat_q` on the next cycle. Bit 3 is ready (not programming), bit 2 is address error, bit 1 is write-protect violation and bit 0 is CRC error. A read clears the error flags unless an error is flagged in the same cycle.
- R11: A single-block write returns to idle after its token. A multi-block write accepts further blocks until stop. Stop returns to idle from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr_start | input | 1 | Write start strobe |
| cmd_multi | input | 1 | 1 = multi-block write, 0 = single block |
| cmd_blk_len | input | LEN_W | Block length in bits, 1..BLK_BITS |
| cmd_addr_off | input | OFF_W | Starting bit offset within a block |
| cmd_wp | input | 1 | Target area is write protected |
| cmd_stop | input | 1 | Stop strobe |
| cmd_sel | input | 1 | Select strobe |
| cmd_desel | input | 1 | Deselect strobe |
| cfg_misalign_ok | input | 1 | Allow blocks crossing a boundary |
| dat_in | input | 1 | Data line from host |
| dat_out | output | 1 | Data line value driven by card |
| dat_oe | output | 1 | Card drives the data line |
| stat_rd | input | 1 | Status read strobe |
| stat_q | output | 4 | {ready, addr_err, wp_err, crc_err} |

## Verification
A wrong internal state shows at the ports within one token or one status read. A wrong CRC register or shift counter appears as the wrong token code, or as a token shifted in time, exactly two cycles after the end bit. A wrong offset or abort state shows as a token given to a block that should have been ignored, or as a missing address-error bit on the next read. A fault in the program timer or the select state shows as a busy interval of the wrong length, or as a line still driven one cycle after deselect. The bench therefore counts the busy cycles exactly. It also sweeps every offset and length pair.

// File: rtl/card_wr_rx_pkg.sv
package card_wr_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_WAIT_START = 3'd1,
        S_SHIFT      = 3'd2,
        S_END        = 3'd3,
        S_GAP        = 3'd4,
        S_TOK        = 3'd5,
        S_WAIT_STOP  = 3'd6
    } rx_state_e;

    localparam int          CRC_BITS = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [2:0]  TOK_OK   = 3'b010;
    localparam logic [2:0]  TOK_BAD  = 3'b101;
    localparam logic [2:0]  TOK_LAST = 3'd4;

endpackage

// File: rtl/card_wr_crc16.sv
module card_wr_crc16 #(
    parameter int                WIDTH = 16,
    parameter logic [WIDTH-1:0]  POLY  = 16'h1021
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] crc_q,
    output logic             zero
);
    logic             fb;
    logic [WIDTH-1:0] nxt;

    assign fb = crc_q[WIDTH-1] ^ bit_in;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            if (i == 0) begin : g_lsb
                assign nxt[i] = POLY[i] & fb;
            end else begin : g_up
                assign nxt[i] = crc_q[i-1] ^ (POLY[i] & fb);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc_q <= '0;
        else if (clr) crc_q <= '0;
        else if (en)  crc_q <= nxt;
    end

    assign zero = (crc_q == '0);
endmodule

// File: rtl/card_wr_prog_timer.sv
module card_wr_prog_timer #(
    parameter int PROG_CYC = 40,
    localparam int PW = $clog2(PROG_CYC + 1)
)(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= PW'(PROG_CYC);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/card_wr_status.sv
module card_wr_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  logic       ready,
    input  logic       set_addr,
    input  logic       set_wp,
    input  logic       set_crc,
    output logic [2:0] err_q,
    output logic [3:0] stat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= '0;
            stat_q <= '0;
        end else begin
            if (rd) stat_q <= {ready, err_q};
            err_q <= (rd ? 3'b000 : err_q) | {set_addr, set_wp, set_crc};
        end
    end
endmodule

// File: rtl/card_wr_rx.sv
module card_wr_rx
    import card_wr_rx_pkg::*;
#(
    parameter int BLK_BITS = 32,
    parameter int PROG_CYC = 40,
    localparam int LEN_W = $clog2(BLK_BITS) + 1,
    localparam int OFF_W = $clog2(BLK_BITS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_start,
    input  logic             cmd_multi,
    input  logic [LEN_W-1:0] cmd_blk_len,
    input  logic [OFF_W-1:0] cmd_addr_off,
    input  logic             cmd_wp,
    input  logic             cmd_stop,
    input  logic             cmd_sel,
    input  logic             cmd_desel,
    input  logic             cfg_misalign_ok,
    input  logic             dat_in,
    output logic             dat_out,
    output logic             dat_oe,
    input  logic             stat_rd,
    output logic [3:0]       stat_q
);
    localparam int CNT_W = $clog2(BLK_BITS + CRC_BITS + 1);
    localparam int SUM_W = LEN_W + 1;

    rx_state_e         state_q, state_d;
    logic              sel_q, multi_q, fail_q;
    logic [LEN_W-1:0]  len_q;
    logic [OFF_W-1:0]  off_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [2:0]        tok_cnt;
    logic [2:0]        tok_code_q;
    logic [4:0]        tok_frame;
    logic [15:0]       crc_q;
    logic              crc_ok;
    logic              prog_busy, prog_load;
    logic              set_addr, set_wp, set_crc;
    logic [2:0]        err_vec;
    logic              mis_first, mis_next;
    logic              go_start, start_seen, shift_last, tok_last;

    function automatic logic crosses(input logic allow,
                                     input logic [OFF_W-1:0] off,
                                     input logic [LEN_W-1:0] len);
        return !allow && ((SUM_W'(off) + SUM_W'(len)) > SUM_W'(BLK_BITS));
    endfunction

    assign mis_first  = crosses(cfg_misalign_ok, cmd_addr_off, cmd_blk_len);
    assign mis_next   = crosses(cfg_misalign_ok, off_q, len_q);
    assign go_start   = (state_q == S_IDLE) && sel_q && cmd_wr_start
                        && !cmd_stop && !cmd_desel;
    assign start_seen = (state_q == S_WAIT_START) && !dat_in && !prog_busy;
    assign shift_last = (bit_cnt == CNT_W'(len_q) + CNT_W'(CRC_BITS - 1));
    assign tok_last   = (tok_cnt == TOK_LAST);
    assign prog_load  = (state_q == S_END) && crc_ok;
    assign set_crc    = (state_q == S_END) && !crc_ok;
    assign tok_frame  = {1'b0, tok_code_q, 1'b1};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and abort flags
    always_comb begin
        state_d  = state_q;
        set_addr = 1'b0;
        set_wp   = 1'b0;
        if (cmd_desel || cmd_stop) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (sel_q && cmd_wr_start) begin
                        if (cmd_wp) begin
                            set_wp = 1'b1;
                        end else if (mis_first) begin
                            set_addr = 1'b1;
                            state_d  = S_WAIT_STOP;
                        end else begin
                            state_d = S_WAIT_START;
                        end
                    end
                end
                S_WAIT_START: if (start_seen) state_d = S_SHIFT;
                S_SHIFT:      if (shift_last) state_d = S_END;
                S_END:        state_d = S_GAP;
                S_GAP:        state_d = S_TOK;
                S_TOK: begin
                    if (tok_last) begin
                        if (fail_q) begin
                            state_d = multi_q ? S_WAIT_STOP : S_IDLE;
                        end else if (!multi_q) begin
                            state_d = S_IDLE;
                        end else if (mis_next) begin
                            set_addr = 1'b1;
                            state_d  = S_WAIT_STOP;
                        end else begin
                            state_d = S_WAIT_START;
                        end
                    end
                end
                S_WAIT_STOP:  state_d = S_WAIT_STOP;
                default:      state_d = S_IDLE;
            endcase
        end
    end

    // transfer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= 1'b0;
            multi_q    <= 1'b0;
            fail_q     <= 1'b0;
            len_q      <= '0;
            off_q      <= '0;
            bit_cnt    <= '0;
            tok_cnt    <= '0;
            tok_code_q <= TOK_OK;
        end else begin
            if (cmd_desel)    sel_q <= 1'b0;
            else if (cmd_sel) sel_q <= 1'b1;

            if (go_start) begin
                multi_q <= cmd_multi;
                len_q   <= cmd_blk_len;
                off_q   <= cmd_addr_off;
                fail_q  <= 1'b0;
            end

            if (state_q == S_WAIT_START) bit_cnt <= '0;
            else if (state_q == S_SHIFT) bit_cnt <= bit_cnt + 1'b1;

            if (state_q == S_END) begin
                tok_code_q <= crc_ok ? TOK_OK : TOK_BAD;
                fail_q     <= !crc_ok;
                if (crc_ok) off_q <= off_q + len_q[OFF_W-1:0];
            end

            if (state_q == S_TOK) tok_cnt <= tok_cnt + 1'b1;
            else                  tok_cnt <= '0;
        end
    end

    // line outputs
    always_comb begin
        dat_oe  = 1'b0;
        dat_out = 1'b1;
        unique case (state_q)
            S_TOK: begin
                dat_oe  = 1'b1;
                dat_out = tok_frame[3'(TOK_LAST - tok_cnt)];
            end
            S_IDLE, S_WAIT_START, S_WAIT_STOP: begin
                if (sel_q && prog_busy) begin
                    dat_oe  = 1'b1;
                    dat_out = 1'b0;
                end
            end
            default: begin
                dat_oe  = 1'b0;
                dat_out = 1'b1;
            end
        endcase
    end

    card_wr_crc16 #(.WIDTH(CRC_BITS), .POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == S_WAIT_START),
        .en     (state_q == S_SHIFT),
        .bit_in (dat_in),
        .crc_q  (crc_q),
        .zero   (crc_ok)
    );

    card_wr_prog_timer #(.PROG_CYC(PROG_CYC)) u_prog (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (prog_load),
        .busy  (prog_busy)
    );

    card_wr_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (stat_rd),
        .ready    (!prog_busy),
        .set_addr (set_addr),
        .set_wp   (set_wp),
        .set_crc  (set_crc),
        .err_q    (err_vec),
        .stat_q   (stat_q)
    );
endmodule

// File: rtl/card_wr_rx_chk.sv
module card_wr_rx_chk
    import card_wr_rx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input rx_state_e  state_q,
    input logic       sel_q,
    input logic       prog_busy,
    input logic       crc_ok,
    input logic       cmd_wr_start,
    input logic       cmd_wp,
    input logic       cmd_stop,
    input logic       cmd_sel,
    input logic       cmd_desel,
    input logic       dat_oe,
    input logic       dat_out,
    input logic       stat_rd,
    input logic [3:0] stat_q,
    input logic [2:0] err_vec,
    input logic       set_addr,
    input logic       set_wp,
    input logic       set_crc
);
    a_r3_token_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP && !cmd_desel && !cmd_stop) |=> (dat_oe && !dat_out));

    a_r3_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP) |-> !dat_oe);

    a_r4_crc_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_END && !crc_ok) |=> err_vec[0]);

    a_r5_no_rx_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> (state_q != S_SHIFT));

    a_r5_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_oe && state_q != S_TOK) |-> !dat_out);

    a_r7_wp_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && sel_q && cmd_wr_start && cmd_wp && !cmd_stop && !cmd_desel)
        |=> (state_q == S_IDLE && err_vec[1]));

    a_r8_desel_release: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_desel |=> !dat_oe);

    a_r9_resel_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_sel) && !$past(cmd_desel) && prog_busy && state_q == S_IDLE)
        |-> (dat_oe && !dat_out));

    a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (stat_q[3] == !$past(prog_busy)));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !set_addr && !set_wp && !set_crc) |=> (err_vec == 3'b000));
endmodule

bind card_wr_rx card_wr_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .sel_q        (sel_q),
    .prog_busy    (prog_busy),
    .crc_ok       (crc_ok),
    .cmd_wr_start (cmd_wr_start),
    .cmd_wp       (cmd_wp),
    .cmd_stop     (cmd_stop),
    .cmd_sel      (cmd_sel),
    .cmd_desel    (cmd_desel),
    .dat_oe       (dat_oe),
    .dat_out      (dat_out),
    .stat_rd      (stat_rd),
    .stat_q       (stat_q),
    .err_vec      (err_vec),
    .set_addr     (set_addr),
    .set_wp       (set_wp),
    .set_crc      (set_crc)
);

// File: tb/card_wr_rx_bench.sv
module card_wr_rx_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BLK  = 32;
    localparam int PROG = 40;
    localparam int LW   = $clog2(BLK) + 1;
    localparam int OW   = $clog2(BLK);
    localparam logic [4:0] T_OK  = 5'b00101;
    localparam logic [4:0] T_BAD = 5'b01011;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr_start = 1'b0, cmd_multi = 1'b0, cmd_wp = 1'b0;
    logic [LW-1:0] cmd_blk_len = '0;
    logic [OW-1:0] cmd_addr_off = '0;
    logic          cmd_stop = 1'b0, cmd_sel = 1'b0, cmd_desel = 1'b0;
    logic          cfg_misalign_ok = 1'b0;
    logic          dat_in = 1'b1;
    logic          dat_out, dat_oe;
    logic          stat_rd = 1'b0;
    logic [3:0]    stat_q;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    card_wr_rx #(.BLK_BITS(BLK), .PROG_CYC(PROG)) u_card_wr_rx (
        .clk(clk), .rst_n(rst_n), .cmd_wr_start(cmd_wr_start), .cmd_multi(cmd_multi),
        .cmd_blk_len(cmd_blk_len), .cmd_addr_off(cmd_addr_off), .cmd_wp(cmd_wp),
        .cmd_stop(cmd_stop), .cmd_sel(cmd_sel), .cmd_desel(cmd_desel),
        .cfg_misalign_ok(cfg_misalign_ok), .dat_in(dat_in), .dat_out(dat_out),
        .dat_oe(dat_oe), .stat_rd(stat_rd), .stat_q(stat_q)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input logic [31:0] d, input int len);
        logic [15:0] c = '0;
        for (int i = len - 1; i >= 0; i--) begin
            logic fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic next_seed();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
    endtask

    task automatic start_wr(input bit multi, input int len, input int off, input bit wp);
        @(negedge clk);
        cmd_multi = multi; cmd_blk_len = LW'(len); cmd_addr_off = OW'(off); cmd_wp = wp;
        cmd_wr_start = 1'b1;
        @(negedge clk);
        cmd_wr_start = 1'b0; cmd_wp = 1'b0;
    endtask

    task automatic stop_wr();
        @(negedge clk) cmd_stop = 1'b1;
        @(negedge clk) cmd_stop = 1'b0;
    endtask

    task automatic read_stat(output logic [3:0] v);
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
        v = stat_q;
    endtask

    task automatic send_block(input logic [31:0] d, input int len, input bit bad,
                              output logic [4:0] tok, output int oe_cnt, output bit busy0);
        logic [15:0] c;
        c = crc_ref(d, len);
        if (bad) c = c ^ 16'h0100;
        oe_cnt = 0;
        tok = '0;
        @(negedge clk) dat_in = 1'b0;
        for (int i = len - 1; i >= 0; i--) begin @(negedge clk) dat_in = d[i]; end
        for (int i = 15; i >= 0; i--) begin @(negedge clk) dat_in = c[i]; end
        @(negedge clk) dat_in = 1'b1;
        @(negedge clk) if (dat_oe) oe_cnt++;
        for (int i = 4; i >= 0; i--) begin
            @(negedge clk);
            tok[i] = dat_out;
            if (dat_oe) oe_cnt++;
        end
        @(negedge clk) busy0 = dat_oe && !dat_out;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (dat_oe && !dat_out) n++;
            else break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] tok;
        logic [3:0] st;
        int oe_n, n;
        bit b0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "dat_oe after reset", dat_oe, 0);
        chk("R1", "stat_q after reset", stat_q, 0);
        read_stat(st);
        chk("R1", "first status read", st, 4'b1000);

        @(negedge clk) cmd_sel = 1'b1;
        @(negedge clk) cmd_sel = 1'b0;

        // R2 R3 R4 R5: single-block sweep over lengths, good and corrupted CRC
        for (int k = 0; k < 24; k++) begin
            int len = 1 + (k * 7) % BLK;
            bit bad = (k % 3 == 1);
            next_seed();
            start_wr(1'b0, len, 0, 1'b0);
            send_block(seed, len, bad, tok, oe_n, b0);
            chk("R3", "token cycles driven", oe_n, 5);
            chk(bad ? "R4" : "R2", "token value", tok, bad ? T_BAD : T_OK);
            if (!bad) begin
                chk("R5", "busy after token", b0, 1);
                count_busy(n);
                chk("R5", "busy length", n, PROG - 7);
            end else begin
                chk("R4", "no busy after bad block", b0, 0);
            end
            read_stat(st);
            chk(bad ? "R4" : "R10", "status after block", st, bad ? 4'b1001 : 4'b1000);
        end

        // R5 R10: ready flag low while programming
        start_wr(1'b0, 32, 0, 1'b0);
        send_block(32'hA5C3_0F1E, 32, 1'b0, tok, oe_n, b0);
        read_stat(st);
        chk("R5", "ready low while programming", st, 4'b0000);
        count_busy(n);
        chk("R5", "remaining busy after read", n, PROG - 9);
        read_stat(st);
        chk("R10", "ready back after programming", st, 4'b1000);

        // R8 R9: deselect and reselect during programming
        start_wr(1'b0, 16, 0, 1'b0);
        send_block(32'h0000_BEEF, 16, 1'b0, tok, oe_n, b0);
        chk("R8", "busy before deselect", b0, 1);
        @(negedge clk) cmd_desel = 1'b1;
        @(negedge clk) cmd_desel = 1'b0;
        chk("R8", "line released after deselect", dat_oe, 0);
        @(negedge clk) cmd_sel = 1'b1;
        @(negedge clk) cmd_sel = 1'b0;
        chk("R9", "busy restored oe", dat_oe, 1);
        chk("R9", "busy restored level", dat_out, 0);
        count_busy(n);
        chk("R8", "programming not interrupted", n, PROG - 11);

        // R11: multi-block with two good blocks
        start_wr(1'b1, 32, 0, 1'b0);
        send_block(32'h1357_9BDF, 32, 1'b0, tok, oe_n, b0);
        chk("R11", "multi block 1 token", tok, T_OK);
        count_busy(n);
        send_block(32'h2468_ACE0, 32, 1'b0, tok, oe_n, b0);
        chk("R11", "multi block 2 token", tok, T_OK);
        chk("R11", "multi block 2 driven", oe_n, 5);
        count_busy(n);
        chk("R5", "multi block 2 busy", n, PROG - 7);
        stop_wr();
        read_stat(st);
        chk("R11", "status after multi", st, 4'b1000);

        // R4: CRC failure in multi-block ignores later blocks
        start_wr(1'b1, 24, 0, 1'b0);
        send_block(32'h00C0_FFEE, 24, 1'b1, tok, oe_n, b0);
        chk("R4", "multi bad token", tok, T_BAD);
        send_block(32'h0012_3456, 24, 1'b0, tok, oe_n, b0);
        chk("R4", "later block ignored", oe_n, 0);
        read_stat(st);
        chk("R4", "status crc error", st, 4'b1001);
        stop_wr();
        // R11: stop returns to idle, new write works
        start_wr(1'b0, 24, 0, 1'b0);
        send_block(32'h0012_3456, 24, 1'b0, tok, oe_n, b0);
        chk("R11", "write after stop", tok, T_OK);
        count_busy(n);
        // R11: single write returned to idle, block without start ignored
        send_block(32'h0000_0055, 8, 1'b0, tok, oe_n, b0);
        chk("R11", "single done ignores block", oe_n, 0);

        // R6: misalignment found before second block
        start_wr(1'b1, 16, 8, 1'b0);
        send_block(32'h0000_F00D, 16, 1'b0, tok, oe_n, b0);
        chk("R6", "first aligned block", tok, T_OK);
        count_busy(n);
        send_block(32'h0000_D00F, 16, 1'b0, tok, oe_n, b0);
        chk("R6", "misaligned block ignored", oe_n, 0);
        read_stat(st);
        chk("R6", "address error status", st, 4'b1100);
        stop_wr();

        // R6: misalignment permitted by configuration
        cfg_misalign_ok = 1'b1;
        start_wr(1'b0, 16, 24, 1'b0);
        send_block(32'h0000_7E57, 16, 1'b0, tok, oe_n, b0);
        chk("R6", "misaligned allowed token", tok, T_OK);
        count_busy(n);
        for (int off = 0; off < BLK; off++) begin
            start_wr(1'b0, BLK, off, 1'b0);
            read_stat(st);
            chk("R6", "allowed sweep status", st, 4'b1000);
            stop_wr();
        end
        cfg_misalign_ok = 1'b0;

        // R7 R10: write-protect abort, then error cleared by read
        start_wr(1'b0, 16, 0, 1'b1);
        send_block(32'h0000_1111, 16, 1'b0, tok, oe_n, b0);
        chk("R7", "protected block ignored", oe_n, 0);
        read_stat(st);
        chk("R7", "wp status", st, 4'b1010);
        read_stat(st);
        chk("R10", "error cleared by read", st, 4'b1000);

        // R6: exhaustive offset/length sweep
        for (int off = 0; off < BLK; off++) begin
            for (int len = 1; len <= BLK; len++) begin
                start_wr(1'b1, len, off, 1'b0);
                read_stat(st);
                chk("R6", "sweep status", st, (off + len > BLK) ? 4'b1100 : 4'b1000);
                stop_wr();
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule